// File: doc/BRIEF.md
# Distributed Bus Arbitration Agent

This block is the local contender that one bus client uses to win a shared bus with sixteen priority levels. The bus has no central comparator. Every agent that wants the bus pulls a common open-collector request line low. When the arbitrate/grant line then rises, each contender puts its 4-bit level on a wired-AND arbitration bus. Each agent watches the settled bus from the most significant bit down. As soon as a higher-priority value shows at a bit where its own level is 1, it stops driving all of its lower bits. After that the bus converges to the numerically lowest competing level.

A level bit of 0 is sent by pulling that bus line low. Level 0 therefore ranks highest and level 15 ranks lowest. After a programmable number of settling clocks, the agent compares the sampled bus with its own level. When the grant phase starts (the arbitrate/grant line falls), a matching agent becomes the owner. The owner drives its full level for the whole tenure, drops its request, and may signal burst intent. It withdraws burst once any other agent pulls the request line. When the client drops its request, the agent releases every drive at once.

Top module: `arb_agent`

## Requirements
- R1: After reset, all arbitration drive enables, the request drive, the burst drive and the granted flag are 0.
- R2: The request drive (1 = pull the shared request line low) is 1 while the client requests and the agent is not the owner, and stays 1 after a lost contest. It is 0 while granted.
- R3: In the cycle after a rising edge of the arbitrate/grant line, a requesting agent latches its level and drives enable bit i to 1 for every level bit i that is 0. Before any competitor is seen, the drive equals the bitwise inverse of the level.
- R4: The agent never pulls a bus bit whose level bit is 1. Once the sampled bus shows 0 at a higher bit where its level has 1, it stops driving every lower bit.
- R5: The agent counts settle_i clocks in the contest and then records a win only if the sampled bus equals its latched level. It becomes the owner at the next falling edge of the arbitrate/grant line. Among distinct contending levels, only the lowest is granted.
- R6: While granted, the drive enables equal the bitwise inverse of the latched level, so the bus shows the owner's level.
- R7: The burst drive is 1 only while granted and the client asks for burst. It goes to 0 for the rest of the tenure once the shared request line is seen low while the agent owns the bus.
- R8: When the client drops its request, all drives and the granted flag are 0 from the next cycle on.
- R9: If the grant phase begins before the settling count has completed, the agent is not granted and keeps its request driven.
- R10: A change of level_i after the contest has started has no effect on that contest or on the tenure that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Client wants the bus |
| burst_req_i | input | 1 | Client intends back-to-back transfers |
| level_i | input | LVL_W | Configured priority level, 0 highest |
| settle_i | input | SET_W | Settling clocks before the decision |
| arb_gnt_i | input | 1 | Arbitrate (1) / grant (0) line |
| arb_bus_i | input | LVL_W | Sampled wired-AND arbitration bus |
| preempt_line_i | input | 1 | Sampled shared request line, low when any agent requests |
| arb_drv_o | output | LVL_W | Per-bit enables, 1 pulls that bus bit low |
| preempt_drv_o | output | 1 | 1 pulls the shared request line low |
| burst_drv_o | output | 1 | 1 pulls the burst line low |
| granted_o | output | 1 | Agent owns the bus |

## Verification
Every cycle, the assertions check these invariants: a level bit of 1 is never pulled, the owner drives its full level and never requests, burst appears only under grant, and ownership begins only after the grant phase has started and ends the cycle after the client lets go. Only the bench scenarios can show which agent wins a contest of two to four agents. The same applies to the per-bit withdrawal pattern partway through a contest, the effect of a grant phase that starts too early, and burst being withdrawn when a rival makes a request.

// File: rtl/arb_agent_pkg.sv
`timescale 1ns/1ps
package arb_agent_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_ARB,
    ST_SETL,
    ST_OWN
  } arb_st_e;
endpackage

// File: rtl/arb_gnt_edge.sv
`timescale 1ns/1ps
module arb_gnt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic rise_o,
  output logic fall_o
);
  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b0;
    else         line_q <= line_i;
  end

  assign rise_o = line_i & ~line_q;
  assign fall_o = ~line_i & line_q;
endmodule

// File: rtl/arb_settle_cnt.sv
`timescale 1ns/1ps
module arb_settle_cnt #(
  parameter int SET_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SET_W-1:0] settle_i,
  output logic             done_o
);
  logic [SET_W-1:0] cnt_q;

  assign done_o = (cnt_q >= settle_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/arb_lvl_drive.sv
`timescale 1ns/1ps
module arb_lvl_drive #(
  parameter int LVL_W = 4
) (
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] bus_i,
  input  logic             compete_i,
  input  logic             own_i,
  output logic [LVL_W-1:0] drv_o
);
  // outranked[i]: a higher bit shows 0 on the bus where our level has 1
  logic [LVL_W-1:0] outranked;

  always_comb begin
    outranked[LVL_W-1] = 1'b0;
    for (int i = LVL_W-2; i >= 0; i--) begin
      outranked[i] = outranked[i+1] | (lvl_i[i+1] & ~bus_i[i+1]);
    end
  end

  for (genvar g = 0; g < LVL_W; g++) begin : g_bit
    assign drv_o[g] = own_i ? ~lvl_i[g]
                            : (compete_i & ~lvl_i[g] & ~outranked[g]);
  end
endmodule

// File: rtl/arb_agent.sv
`timescale 1ns/1ps
module arb_agent
  import arb_agent_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int SET_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             burst_req_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [SET_W-1:0] settle_i,
  input  logic             arb_gnt_i,
  input  logic [LVL_W-1:0] arb_bus_i,
  input  logic             preempt_line_i,
  output logic [LVL_W-1:0] arb_drv_o,
  output logic             preempt_drv_o,
  output logic             burst_drv_o,
  output logic             granted_o
);
  arb_st_e          st_q, st_d;
  logic [LVL_W-1:0] lvl_q, bus_q;
  logic             won_q, yield_q;
  logic             rise, fall, settled;
  logic             in_arb, competing, owning, enter_arb;

  assign in_arb    = (st_q == ST_ARB);
  assign competing = (st_q == ST_ARB) || (st_q == ST_SETL);
  assign owning    = (st_q == ST_OWN);
  assign enter_arb = (st_d == ST_ARB) && !in_arb;

  arb_gnt_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (arb_gnt_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  arb_settle_cnt #(.SET_W(SET_W)) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!in_arb),
    .settle_i (settle_i),
    .done_o   (settled)
  );

  arb_lvl_drive #(.LVL_W(LVL_W)) u_drv (
    .lvl_i     (lvl_q),
    .bus_i     (bus_q),
    .compete_i (competing),
    .own_i     (owning),
    .drv_o     (arb_drv_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_i) st_d = ST_PEND;
      ST_PEND: begin
        if (!req_i)    st_d = ST_IDLE;
        else if (rise) st_d = ST_ARB;
      end
      ST_ARB: begin
        if (!req_i)       st_d = ST_IDLE;
        else if (fall)    st_d = ST_PEND;  // grant phase came too early
        else if (settled) st_d = ST_SETL;
      end
      ST_SETL: begin
        if (!req_i)    st_d = ST_IDLE;
        else if (fall) st_d = won_q ? ST_OWN : ST_PEND;
      end
      ST_OWN: begin
        if (!req_i)    st_d = ST_IDLE;
        else if (rise) st_d = ST_ARB;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      lvl_q   <= '0;
      bus_q   <= '1;
      won_q   <= 1'b0;
      yield_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      bus_q <= arb_bus_i;
      if (enter_arb) lvl_q <= level_i;
      if (in_arb && st_d == ST_SETL) won_q <= (bus_q == lvl_q);
      else if (enter_arb)            won_q <= 1'b0;
      if (!owning)              yield_q <= 1'b0;
      else if (!preempt_line_i) yield_q <= 1'b1;
    end
  end

  assign granted_o     = owning;
  assign preempt_drv_o = (st_q == ST_PEND) || competing;
  assign burst_drv_o   = owning & burst_req_i & ~yield_q;
endmodule

// File: rtl/arb_agent_chk.sv
`timescale 1ns/1ps
module arb_agent_chk #(
  parameter int LVL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             arb_gnt_i,
  input logic [LVL_W-1:0] lvl_q,
  input logic [LVL_W-1:0] arb_drv_o,
  input logic             preempt_drv_o,
  input logic             burst_drv_o,
  input logic             granted_o
);
  // R2
  owner_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    granted_o |-> !preempt_drv_o);

  // R4
  no_pull_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_drv_o & lvl_q) == '0);

  // R5
  grant_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(granted_o) |-> !$past(arb_gnt_i));

  // R6
  full_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    granted_o |-> (arb_drv_o == ~lvl_q));

  // R7
  burst_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_drv_o |-> granted_o);

  // R8
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (granted_o && !req_i) |=> (!granted_o && arb_drv_o == '0 && !burst_drv_o));
endmodule

bind arb_agent arb_agent_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .arb_gnt_i     (arb_gnt_i),
  .lvl_q         (lvl_q),
  .arb_drv_o     (arb_drv_o),
  .preempt_drv_o (preempt_drv_o),
  .burst_drv_o   (burst_drv_o),
  .granted_o     (granted_o)
);

// File: tb/arb_agent_test.sv
`timescale 1ns/1ps
module arb_agent_test;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       arb_gnt;
  logic [3:0] settle;
  logic       req [N];
  logic       bst [N];
  logic [3:0] lvl [N];
  logic [3:0] drv [N];
  logic       pdrv [N];
  logic       bdrv [N];
  logic       gnt [N];
  logic [3:0] bus;
  logic       pline;
  int         n_chk = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;

  // wired-AND of active-low open-collector drivers
  always_comb begin
    bus   = 4'hF;
    pline = 1'b1;
    for (int k = 0; k < N; k++) begin
      bus   = bus & ~drv[k];
      pline = pline & ~pdrv[k];
    end
  end

  arb_agent uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[0]), .burst_req_i(bst[0]),
    .level_i(lvl[0]), .settle_i(settle), .arb_gnt_i(arb_gnt),
    .arb_bus_i(bus), .preempt_line_i(pline), .arb_drv_o(drv[0]),
    .preempt_drv_o(pdrv[0]), .burst_drv_o(bdrv[0]), .granted_o(gnt[0])
  );

  for (genvar g = 1; g < N; g++) begin : g_peer
    arb_agent u_ag (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req[g]), .burst_req_i(bst[g]),
      .level_i(lvl[g]), .settle_i(settle), .arb_gnt_i(arb_gnt),
      .arb_bus_i(bus), .preempt_line_i(pline), .arb_drv_o(drv[g]),
      .preempt_drv_o(pdrv[g]), .burst_drv_o(bdrv[g]), .granted_o(gnt[g])
    );
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] gnt_vec();
    return {gnt[3], gnt[2], gnt[1], gnt[0]};
  endfunction

  task automatic do_reset();
    rst_n   = 1'b0;
    arb_gnt = 1'b0;
    for (int k = 0; k < N; k++) begin
      req[k] = 1'b0; bst[k] = 1'b0; lvl[k] = 4'hF;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic start_arb();
    arb_gnt = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_arb();
    repeat (12) @(negedge clk);
    arb_gnt = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 drv",     drv[0],  4'h0);
    chk("R1 preempt", pdrv[0], 1'b0);
    chk("R1 burst",   bdrv[0], 1'b0);
    chk("R1 granted", gnt[0],  1'b0);
  endtask

  task automatic t_two();
    do_reset();
    lvl[0] = 4'h5; lvl[1] = 4'h3; req[0] = 1'b1; req[1] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 preempt pending", pdrv[0], 1'b1);
    start_arb();
    chk("R3 first drive", drv[0], 4'hA);
    repeat (8) @(negedge clk);
    chk("R4 withdrawn low bits", drv[0], 4'h8);
    chk("R5 settled bus", bus, 4'h3);
    finish_arb();
    chk("R5 lowest granted", gnt_vec(), 4'b0010);
    chk("R2 loser keeps preempt", pdrv[0], 1'b1);
    chk("R2 owner drops preempt", pdrv[1], 1'b0);
    chk("R6 owner level on bus", bus, 4'h3);
    chk("R4 loser idle drive", drv[0], 4'h0);
    chk("R7 no burst without intent", bdrv[1], 1'b0);
  endtask

  task automatic t_four();
    do_reset();
    lvl[0] = 4'h9; lvl[1] = 4'h2; lvl[2] = 4'hA; lvl[3] = 4'h7;
    for (int k = 0; k < N; k++) req[k] = 1'b1;
    repeat (2) @(negedge clk);
    start_arb();
    finish_arb();
    chk("R5 four agents", gnt_vec(), 4'b0010);
    chk("R6 bus value", bus, 4'h2);
  endtask

  task automatic t_bounds();
    do_reset();
    lvl[0] = 4'h0; lvl[1] = 4'h1; req[0] = 1'b1; req[1] = 1'b1;
    repeat (2) @(negedge clk);
    start_arb();
    finish_arb();
    chk("R5 level 0 wins", gnt_vec(), 4'b0001);
    chk("R6 level 0 full drive", drv[0], 4'hF);
    do_reset();
    lvl[0] = 4'hF; lvl[2] = 4'hE; req[0] = 1'b1; req[2] = 1'b1;
    repeat (2) @(negedge clk);
    start_arb();
    finish_arb();
    chk("R5 level E beats F", gnt_vec(), 4'b0100);
  endtask

  task automatic t_level_change();
    do_reset();
    lvl[0] = 4'h4; lvl[1] = 4'h6; req[0] = 1'b1; req[1] = 1'b1;
    repeat (2) @(negedge clk);
    start_arb();
    lvl[0] = 4'h7;
    finish_arb();
    chk("R10 latched level wins", gnt_vec(), 4'b0001);
    chk("R10 latched level driven", drv[0], 4'hB);
  endtask

  task automatic t_burst();
    do_reset();
    lvl[0] = 4'h8; req[0] = 1'b1; bst[0] = 1'b1; lvl[1] = 4'h1;
    repeat (2) @(negedge clk);
    start_arb();
    finish_arb();
    chk("R7 burst while owner", bdrv[0], 1'b1);
    req[1] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 burst yielded", bdrv[0], 1'b0);
    chk("R7 still owner", gnt[0], 1'b1);
    req[0] = 1'b0;
    @(negedge clk);
    chk("R8 released grant", gnt[0], 1'b0);
    chk("R8 released drive", drv[0], 4'h0);
    chk("R8 released burst", bdrv[0], 1'b0);
  endtask

  task automatic t_premature();
    do_reset();
    lvl[0] = 4'h3; lvl[1] = 4'h5; req[0] = 1'b1; req[1] = 1'b1;
    repeat (2) @(negedge clk);
    start_arb();
    @(negedge clk);
    arb_gnt = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 no grant", gnt_vec(), 4'b0000);
    chk("R9 still requesting", pdrv[0], 1'b1);
  endtask

  initial begin
    settle = 4'd6;
    t_reset();
    t_two();
    t_four();
    t_bounds();
    t_level_change();
    t_burst();
    t_premature();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule